// File: doc/BRIEF.md
# Barrel-Threaded Branch Controller

This block sequences instruction fetch for an eight-thread soft processor that issues one instruction per cycle, in order, with no forwarding and no interlocks. It holds a program counter for every hardware thread and visits the threads in a fixed round-robin. Each clock edge it presents the next thread's PC, and that thread's number, to the instruction memory. The block then advances that thread's PC by one. Because a thread comes round only once every eight cycles, an operand loop of up to eight stages never sees a hazard.

Some cycles later the same instruction comes back to the controller as a branch kind, a target address and a test operand. The controller registers these in a first stage. In a second stage it decides whether the branch is taken and, if it is, it overwrites that thread's PC with the target. The thread has already fetched its next sequential instruction by then, so every branch has exactly one delay slot. That slot always runs.

Top module: `barrel_branch_ctl`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` and `fetch_tid` read 0. On release, thread t starts at PC `START_BASE + t*START_STRIDE`, which is 16 + 64*t with the default parameters.
- R2: The first rising edge with `rst_n` high puts thread 0 on the fetch outputs. Each later edge moves to thread (previous + 1) mod 8.
- R3: If no taken branch has redirected a thread, each fetch of that thread gives the PC of its previous fetch plus one, modulo 2^PCW (1023 is followed by 0).
- R4: `ctl_kind` = 0 (plain instruction) leaves every PC unchanged apart from the sequential step.
- R5: `ctl_kind` = 1 is an unconditional jump to `ctl_target`.
- R6: `ctl_kind` = 2 is taken only when every bit of `ctl_value` is 0.
- R7: `ctl_kind` = 3 is taken only when at least one bit of `ctl_value` is 1.
- R8: The inputs for a fetch must be driven during the cycle that begins OP_LAT edges (default 8) after the edge that showed that fetch. A taken branch leaves the thread's next fetch at the sequential address, which is the delay slot. The fetch after that is `ctl_target`.
- R9: Inputs driven during the first OP_LAT cycles after reset release (the cycles after edges 0 to OP_LAT-1) have no effect.
- R10: A taken branch changes the PC of its own thread only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_kind | input | 2 | Branch kind of the returning instruction: 0 none, 1 jump, 2 if zero, 3 if non-zero |
| ctl_target | input | 10 | Branch target address (destination operand) |
| ctl_value | input | 16 | Test operand (source operand value) |
| fetch_pc | output | 10 | PC of the thread that is fetching now |
| fetch_tid | output | 3 | Number of the thread that is fetching now |

## Verification
The assertions assume that the surrounding pipeline returns each instruction exactly OP_LAT cycles after its fetch. They also assume OP_LAT lies between 7 and 13. With those limits, a branch write never falls on the same edge, or the same thread, as the sequential step, and it always lands between the delay-slot fetch and the fetch after it. The bench keeps to these limits by driving exactly one set of inputs per cycle, in step with the rotation. It attributes each set to the thread fetched OP_LAT cycles earlier. During warm-up it deliberately drives jumps that must be ignored.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_JUMP = 2'd1,
    BK_IFZ  = 2'd2,
    BK_IFNZ = 2'd3
  } br_kind_e;

  // Reset PC of one thread.
  function automatic int unsigned thread_start(int unsigned base, int unsigned stride, int unsigned t);
    return base + t * stride;
  endfunction

  // Branch decision from kind and a zero flag of the test operand.
  function automatic logic br_taken(br_kind_e k, logic val_is_zero);
    case (k)
      BK_JUMP: return 1'b1;
      BK_IFZ:  return val_is_zero;
      BK_IFNZ: return !val_is_zero;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/brc_rotor.sv
// Round-robin thread pointer plus warm-up tracking for returning instructions.
module brc_rotor #(
  parameter int NT     = 8,
  parameter int OP_LAT = 8,
  localparam int TW    = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] issue_tid,
  output logic [TW-1:0] exe_tid,
  output logic          exe_ok
);
  localparam int FILL = OP_LAT + 1;
  localparam int FW   = $clog2(FILL + 1);
  localparam int LAG  = FILL % NT;

  logic [FW-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_tid <= '0;
      fill_q    <= '0;
    end else begin
      issue_tid <= issue_tid + TW'(1);
      if (fill_q != FW'(FILL)) fill_q <= fill_q + FW'(1);
    end
  end

  // Thread whose instruction is at the controller inputs this cycle.
  assign exe_tid = issue_tid - TW'(LAG);
  assign exe_ok  = (fill_q == FW'(FILL));

endmodule

// File: rtl/brc_resolve.sv
// CTL0: register the returning instruction. CTL1: decide and produce PC write.
module brc_resolve
  import brc_pkg::*;
#(
  parameter int PCW = 10,
  parameter int DW  = 16,
  parameter int TW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_ok,
  input  br_kind_e       in_kind,
  input  logic [PCW-1:0] in_target,
  input  logic [DW-1:0]  in_value,
  input  logic [TW-1:0]  in_tid,
  output logic           br_we,
  output logic [TW-1:0]  br_tid,
  output logic [PCW-1:0] br_target
);
  logic           s0_ok;
  br_kind_e       s0_kind;
  logic [PCW-1:0] s0_target;
  logic [DW-1:0]  s0_value;
  logic [TW-1:0]  s0_tid;
  logic           s0_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0_ok     <= 1'b0;
      s0_kind   <= BK_NONE;
      s0_target <= '0;
      s0_value  <= '0;
      s0_tid    <= '0;
    end else begin
      s0_ok     <= in_ok;
      s0_kind   <= in_kind;
      s0_target <= in_target;
      s0_value  <= in_value;
      s0_tid    <= in_tid;
    end
  end

  assign s0_zero   = (s0_value == '0);
  assign br_we     = s0_ok && br_taken(s0_kind, s0_zero);
  assign br_tid    = s0_tid;
  assign br_target = s0_target;

endmodule

// File: rtl/brc_pc_file.sv
// Per-thread PC registers, sequential step on issue, redirect on taken branch.
module brc_pc_file
  import brc_pkg::*;
#(
  parameter int NT     = 8,
  parameter int PCW    = 10,
  parameter int BASE   = 16,
  parameter int STRIDE = 64,
  localparam int TW    = $clog2(NT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  iss_tid,
  input  logic           br_we,
  input  logic [TW-1:0]  br_tid,
  input  logic [PCW-1:0] br_target,
  output logic [PCW-1:0] fetch_pc,
  output logic [TW-1:0]  fetch_tid
);
  logic [PCW-1:0] pc_q [NT];
  logic [PCW-1:0] iss_cur;
  logic           started;

  assign iss_cur = pc_q[iss_tid];

  for (genvar t = 0; t < NT; t++) begin : g_pc
    localparam logic [PCW-1:0] START = PCW'(thread_start(BASE, STRIDE, t));
    always_ff @(posedge clk) begin
      if (!rst_n)                                    pc_q[t] <= START;
      else if (br_we && br_tid == TW'(t))            pc_q[t] <= br_target;
      else if (iss_tid == TW'(t))                    pc_q[t] <= pc_q[t] + PCW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc  <= '0;
      fetch_tid <= '0;
      started   <= 1'b0;
    end else begin
      fetch_pc  <= iss_cur;
      fetch_tid <= iss_tid;
      started   <= 1'b1;
    end
  end

  assert_first_thread_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> fetch_tid == '0);

  assert_rotation_R2: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> fetch_tid == $past(fetch_tid) + TW'(1));

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> pc_q[$past(iss_tid)] == $past(iss_cur) + PCW'(1));

  assert_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    br_we |=> pc_q[$past(br_tid)] == $past(br_target));

  assert_no_port_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    br_we |-> br_tid != iss_tid);

endmodule

// File: rtl/barrel_branch_ctl.sv
module barrel_branch_ctl
  import brc_pkg::*;
#(
  parameter int NT           = 8,   // power of two
  parameter int PCW          = 10,
  parameter int DW           = 16,
  parameter int OP_LAT       = 8,   // fetch-to-controller latency, 7..13 for one delay slot
  parameter int START_BASE   = 16,
  parameter int START_STRIDE = 64,
  localparam int TW          = $clog2(NT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     ctl_kind,
  input  logic [PCW-1:0] ctl_target,
  input  logic [DW-1:0]  ctl_value,
  output logic [PCW-1:0] fetch_pc,
  output logic [TW-1:0]  fetch_tid
);
  logic [TW-1:0]  issue_tid;
  logic [TW-1:0]  exe_tid;
  logic           exe_ok;
  logic           br_we;
  logic [TW-1:0]  br_tid;
  logic [PCW-1:0] br_target;

  brc_rotor #(.NT(NT), .OP_LAT(OP_LAT)) u_rotor (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_tid (issue_tid),
    .exe_tid   (exe_tid),
    .exe_ok    (exe_ok)
  );

  brc_resolve #(.PCW(PCW), .DW(DW), .TW(TW)) u_resolve (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ok     (exe_ok),
    .in_kind   (br_kind_e'(ctl_kind)),
    .in_target (ctl_target),
    .in_value  (ctl_value),
    .in_tid    (exe_tid),
    .br_we     (br_we),
    .br_tid    (br_tid),
    .br_target (br_target)
  );

  brc_pc_file #(.NT(NT), .PCW(PCW), .BASE(START_BASE), .STRIDE(START_STRIDE)) u_pcs (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_tid   (issue_tid),
    .br_we     (br_we),
    .br_tid    (br_tid),
    .br_target (br_target),
    .fetch_pc  (fetch_pc),
    .fetch_tid (fetch_tid)
  );

endmodule

// File: tb/barrel_branch_ctl_tb.sv
`timescale 1ns/1ps
module barrel_branch_ctl_tb;
  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ctl_kind = 2'd0;
  logic [9:0]  ctl_target = '0;
  logic [15:0] ctl_value = '0;
  logic [9:0]  fetch_pc;
  logic [2:0]  fetch_tid;

  int    checks = 0;
  int    fails = 0;
  int    m = 0;
  bit    done = 1'b0;
  string cur_req = "R3";
  logic [9:0] exp_pc [8];

  always #5 clk = ~clk;

  barrel_branch_ctl #(.NT(8), .PCW(10), .DW(16), .OP_LAT(LAT),
                      .START_BASE(16), .START_STRIDE(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_kind(ctl_kind), .ctl_target(ctl_target),
    .ctl_value(ctl_value), .fetch_pc(fetch_pc), .fetch_tid(fetch_tid));

  // {kind, target, value}; entry i returns an instruction of thread i mod 8
  localparam logic [27:0] VEC [24] = '{
    {2'd0, 10'd0,    16'h0000}, {2'd1, 10'd200,  16'h0000},
    {2'd2, 10'd300,  16'h0000}, {2'd2, 10'd310,  16'h0001},
    {2'd3, 10'd400,  16'h0005}, {2'd3, 10'd410,  16'h0000},
    {2'd2, 10'd500,  16'h8000}, {2'd1, 10'd1023, 16'h0000},
    {2'd3, 10'd20,   16'hFFFF}, {2'd0, 10'd999,  16'h0000},
    {2'd1, 10'd0,    16'h1234}, {2'd2, 10'd33,   16'h0000},
    {2'd0, 10'd44,   16'hFFFF}, {2'd1, 10'd77,   16'h0000},
    {2'd3, 10'd90,   16'h0001}, {2'd0, 10'd1,    16'h0000},
    {2'd1, 10'd5,    16'h0000}, {2'd2, 10'd6,    16'h0002},
    {2'd0, 10'd7,    16'h0000}, {2'd3, 10'd8,    16'h8000},
    {2'd1, 10'd9,    16'h0000}, {2'd2, 10'd10,   16'h0000},
    {2'd3, 10'd12,   16'h0000}, {2'd1, 10'd11,   16'h0000}
  };

  function automatic bit model_taken(logic [1:0] k, logic [15:0] v);
    if (k == 2'd1) return 1'b1;
    if (k == 2'd2) return (v == 16'h0000);
    if (k == 2'd3) return (v != 16'h0000);
    return 1'b0;
  endfunction

  task automatic model_init();
    for (int t = 0; t < 8; t++) exp_pc[t] = 10'(16 + 64 * t);
    m = 0;
  endtask

  // One cycle: check fetch of edge m, then drive inputs sampled at edge m+1.
  task automatic step(input logic [1:0] k, input logic [9:0] tg, input logic [15:0] v);
    logic [2:0] tid;
    @(negedge clk);
    tid = 3'(m % 8);
    checks++;
    if (fetch_tid !== tid) begin
      fails++;
      $display("FAIL R2 cycle %0d: fetch_tid actual %0d expected %0d", m, fetch_tid, tid);
    end
    checks++;
    if (fetch_pc !== exp_pc[tid]) begin
      fails++;
      $display("FAIL %s cycle %0d thread %0d: fetch_pc actual %0d expected %0d",
               cur_req, m, tid, fetch_pc, exp_pc[tid]);
    end
    exp_pc[tid] = exp_pc[tid] + 10'd1;
    ctl_kind = k; ctl_target = tg; ctl_value = v;
    if (m >= LAT && model_taken(k, v)) exp_pc[3'((m - LAT) % 8)] = tg;  // R8 timing
    m++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ctl_kind = 2'd0; ctl_target = '0; ctl_value = '0;
    repeat (2) @(negedge clk);
    checks++;
    if (fetch_pc !== 10'd0 || fetch_tid !== 3'd0) begin
      fails++;
      $display("FAIL R1: reset outputs actual pc %0d tid %0d expected 0 0", fetch_pc, fetch_tid);
    end
    model_init();
    rst_n = 1'b1;
  endtask

  initial begin
    model_init();
    // R1, R2: reset state and start addresses
    do_reset();
    // R9: jumps during warm-up must be ignored
    cur_req = "R9";
    for (int i = 0; i < LAT; i++) step(2'd1, 10'd5, 16'h0000);
    // R3..R8, R10: table of returning instructions
    cur_req = "R3-R8/R10 vector";
    for (int i = 0; i < 24; i++) step(VEC[i][27:26], VEC[i][25:16], VEC[i][15:0]);
    cur_req = "R8 delay slot and R3 wrap";
    for (int i = 0; i < 24; i++) step(2'd0, 10'd0, 16'h0000);

    // Mid-run reset, then a lone jump on thread 3 (R8, R10)
    do_reset();
    cur_req = "R1 restart";
    for (int i = 0; i < LAT + 3; i++) step(2'd0, 10'd0, 16'h0000);
    cur_req = "R10 single thread";
    step(2'd1, 10'd700, 16'h0000);
    for (int i = 0; i < 20; i++) step(2'd0, 10'd0, 16'h0000);
    // R4, R6, R7: not-taken variants on every thread
    cur_req = "R4/R6/R7 not taken";
    for (int i = 0; i < 8; i++) step(2'(2 + (i % 2)), 10'd900, (i % 2) ? 16'h0000 : 16'h0400);
    for (int i = 0; i < 16; i++) step(2'd0, 10'd0, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule